// File: doc/BRIEF.md
# FM Synthesizer Host Write Port and Global Register Decoder

This block is the host-facing front end of a multi-channel FM sound generator. The host presents a 2-bit port select and an 8-bit data byte on a one-cycle request. The block merges them into a 9-bit write word. Each request passes through a small history register that turns it into a single-cycle enable, and back-to-back requests collapse into one. A self-timed busy indication follows every data write. The host reads it to pace its accesses.

Address writes set the register address. The block holds it for the per-operator and per-channel register files that sit outside it, together with an "operator data pending" flag and the captured data byte. Data writes in the low bank also update a set of global control fields. These cover the LFO, the two timer periods and their control bits, the channel-3 mode and its derived composite-sine mode, the key-on command and the DAC sample and enable.

Top module: `fm_host_regs`

## Requirements
- R1: Port bit 0 selects the request kind: 0 means address write, 1 means data write. The 9-bit write word is {port[1], data[7:0]}.
- R2: Each request is turned into one internal enable. The enable fires in the cycle after the request and lasts one cycle. When requests of one kind arrive in consecutive cycles, only the first acts, and it uses its own word.
- R3: A data write raises `busy` at the second clock edge after its enable cycle. `busy` falls when a 5-bit free-running counter wraps, so it drops within 34 cycles of the last data write. Address writes never raise it.
- R4: An address write whose word bits 7:4 are nonzero loads `reg_addr` with the 9-bit word and marks the address valid. Any other address write clears the valid mark and leaves `reg_addr` unchanged. Every address write clears `op_pending`.
- R5: A data write while the address is valid sets `op_pending`. While `op_pending` is set, `op_data` takes the data byte. A data write with no valid address leaves both unchanged.
- R6: Global fields update only on a data write whose word bit 8 is 0 and whose latched address matches a global register with bit 8 equal to 0.
- R7: Address 0x22 sets `lfo_en` from data bit 3 and `lfo_rate` from data bits 2:0.
- R8: Address 0x24 loads bits 9:2 of `tmra_val` and address 0x25 loads bits 1:0. Each write keeps the other part. Address 0x26 loads `tmrb_val`.
- R9: Address 0x27 sets `ch3_mode` from bits 7:6, with `csm_on` = (bits 7:6 == 2). Bits 0, 2 and 4 give timer A load, enable and reset. Bits 1, 3 and 5 give timer B load, enable and reset.
- R10: Address 0x28 sets `key_ops` from bits 7:4. If bits 1:0 equal 3, `key_chan_bad` is 1 and `key_chan` is 0. Otherwise `key_chan_bad` is 0 and `key_chan` = bits 1:0 + (bit 2 ? 3 : 0).
- R11: Address 0x2A loads `dac_word[8:1]` with data XOR 0x80 and keeps bit 0. Address 0x2B sets `dac_on` from data bit 7.
- R12: While `rst_n` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_req | input | 1 | Write request, one cycle per access |
| wr_port | input | 2 | Port select: bit 0 chooses address or data, bit 1 chooses the bank |
| wr_data | input | 8 | Write data byte |
| busy | output | 1 | Host-visible busy indication |
| op_pending | output | 1 | Operator or channel data is pending for the slot register files |
| reg_addr | output | 9 | Latched register address |
| op_data | output | 8 | Captured data byte for the slot register files |
| lfo_en | output | 1 | LFO enable |
| lfo_rate | output | 3 | LFO rate select |
| tmra_val | output | 10 | Timer A period |
| tmrb_val | output | 8 | Timer B period |
| ch3_mode | output | 2 | Channel-3 mode field |
| csm_on | output | 1 | Composite-sine mode active |
| tmra_load | output | 1 | Timer A load |
| tmra_en | output | 1 | Timer A flag enable |
| tmra_clr | output | 1 | Timer A flag reset |
| tmrb_load | output | 1 | Timer B load |
| tmrb_en | output | 1 | Timer B flag enable |
| tmrb_clr | output | 1 | Timer B flag reset |
| key_ops | output | 4 | Per-operator key flags |
| key_chan | output | 3 | Key-on channel index |
| key_chan_bad | output | 1 | Key-on channel code is invalid |
| dac_word | output | 9 | DAC sample word |
| dac_on | output | 1 | DAC enable |

## Verification
The assertions assume that `wr_req` is a clean synchronous level. They also assume `wr_port` and `wr_data` are valid whenever `wr_req` is high, and that no address and data enable occur in the same cycle. The stimulus drives every input at the falling edge. It normally leaves an idle cycle after each request and issues one kind of request at a time. Only the deliberate back-to-back data case keeps `wr_req` high for two cycles, and that case still uses a single port kind.

// File: rtl/fm_host_pkg.sv
package fm_host_pkg;
  localparam int unsigned WORD_W = 9;
  localparam int unsigned BYTE_W = 8;
  localparam logic [WORD_W-1:0] A_LFO     = 9'h022;
  localparam logic [WORD_W-1:0] A_TMRA_HI = 9'h024;
  localparam logic [WORD_W-1:0] A_TMRA_LO = 9'h025;
  localparam logic [WORD_W-1:0] A_TMRB    = 9'h026;
  localparam logic [WORD_W-1:0] A_MODE    = 9'h027;
  localparam logic [WORD_W-1:0] A_KEY     = 9'h028;
  localparam logic [WORD_W-1:0] A_DAC_VAL = 9'h02A;
  localparam logic [WORD_W-1:0] A_DAC_ON  = 9'h02B;
  localparam logic [1:0]        CH3_CSM   = 2'd2;
endpackage

// File: rtl/fm_req_strobe.sv
module fm_req_strobe (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  output logic fire
);
  logic [1:0] hist_q, hist_n;

  always_comb begin
    hist_n = {hist_q[0], set};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= '0;
    else        hist_q <= hist_n;
  end

  assign fire = (hist_q == 2'b01);
endmodule

// File: rtl/fm_busy_timer.sv
module fm_busy_timer #(
  parameter int unsigned CNT_W = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kick,
  output logic busy_o
);
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             hold_q, hold_n;
  logic             show_q;
  logic             wrap;

  assign wrap = &cnt_q;

  always_comb begin
    cnt_n  = cnt_q + 1'b1;
    hold_n = (hold_q & ~wrap) | kick;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      hold_q <= 1'b0;
      show_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      hold_q <= hold_n;
      show_q <= hold_q;
    end
  end

  assign busy_o = show_q;
endmodule

// File: rtl/fm_addr_track.sv
module fm_addr_track #(
  parameter int unsigned WORD_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              a_en,
  input  logic              d_en,
  input  logic [WORD_W-1:0] word,
  output logic [WORD_W-1:0] addr_o,
  output logic              pend_o,
  output logic [WORD_W-2:0] data_o
);
  logic [WORD_W-1:0] addr_q, addr_n;
  logic              valid_q, valid_n;
  logic              pend_q, pend_n;
  logic [WORD_W-2:0] data_q, data_n;

  always_comb begin
    addr_n  = addr_q;
    valid_n = valid_q;
    pend_n  = pend_q;
    if (a_en) pend_n = 1'b0;
    if (valid_q && d_en) pend_n = 1'b1;
    if (a_en) begin
      if (|word[7:4]) begin
        addr_n  = word;
        valid_n = 1'b1;
      end else begin
        valid_n = 1'b0;
      end
    end
    data_n = pend_n ? word[WORD_W-2:0] : data_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      valid_q <= 1'b0;
      pend_q  <= 1'b0;
      data_q  <= '0;
    end else begin
      addr_q  <= addr_n;
      valid_q <= valid_n;
      pend_q  <= pend_n;
      data_q  <= data_n;
    end
  end

  assign addr_o = addr_q;
  assign pend_o = pend_q;
  assign data_o = data_q;
endmodule

// File: rtl/fm_global_dec.sv
module fm_global_dec
  import fm_host_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              d_en,
  input  logic [WORD_W-1:0] word,
  input  logic [WORD_W-1:0] addr,
  output logic              lfo_en,
  output logic [2:0]        lfo_rate,
  output logic [9:0]        tmra_val,
  output logic [7:0]        tmrb_val,
  output logic [1:0]        ch3_mode,
  output logic              csm_on,
  output logic [2:0]        tmra_ctl,
  output logic [2:0]        tmrb_ctl,
  output logic [3:0]        key_ops,
  output logic [2:0]        key_chan,
  output logic              key_chan_bad,
  output logic [8:0]        dac_word,
  output logic              dac_on
);
  typedef struct packed {
    logic       lfo_en;
    logic [2:0] lfo_rate;
    logic [9:0] tmra;
    logic [7:0] tmrb;
    logic [1:0] ch3;
    logic       csm;
    logic [2:0] actl;
    logic [2:0] bctl;
    logic [3:0] kops;
    logic [2:0] kch;
    logic       kbad;
    logic [8:0] dac;
    logic       dacen;
  } glob_t;

  glob_t st_q, st_n;
  logic  hit;
  logic [BYTE_W-1:0] b;

  assign hit = d_en & ~word[WORD_W-1];
  assign b   = word[BYTE_W-1:0];

  always_comb begin
    st_n = st_q;
    if (hit) begin
      unique case (addr)
        A_LFO: begin
          st_n.lfo_en   = b[3];
          st_n.lfo_rate = b[2:0];
        end
        A_TMRA_HI: st_n.tmra[9:2] = b;
        A_TMRA_LO: st_n.tmra[1:0] = b[1:0];
        A_TMRB:    st_n.tmrb      = b;
        A_MODE: begin
          st_n.ch3  = b[7:6];
          st_n.csm  = (b[7:6] == CH3_CSM);
          st_n.actl = {b[4], b[2], b[0]};
          st_n.bctl = {b[5], b[3], b[1]};
        end
        A_KEY: begin
          st_n.kops = b[7:4];
          if (b[1:0] == 2'd3) begin
            st_n.kbad = 1'b1;
            st_n.kch  = '0;
          end else begin
            st_n.kbad = 1'b0;
            st_n.kch  = {1'b0, b[1:0]} + (b[2] ? 3'd3 : 3'd0);
          end
        end
        A_DAC_VAL: st_n.dac[8:1] = b ^ 8'h80;
        A_DAC_ON:  st_n.dacen    = b[7];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= st_n;
  end

  assign lfo_en       = st_q.lfo_en;
  assign lfo_rate     = st_q.lfo_rate;
  assign tmra_val     = st_q.tmra;
  assign tmrb_val     = st_q.tmrb;
  assign ch3_mode     = st_q.ch3;
  assign csm_on       = st_q.csm;
  assign tmra_ctl     = st_q.actl;
  assign tmrb_ctl     = st_q.bctl;
  assign key_ops      = st_q.kops;
  assign key_chan     = st_q.kch;
  assign key_chan_bad = st_q.kbad;
  assign dac_word     = st_q.dac;
  assign dac_on       = st_q.dacen;
endmodule

// File: rtl/fm_host_regs.sv
module fm_host_regs
  import fm_host_pkg::*;
#(
  parameter int unsigned BUSY_CNT_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_req,
  input  logic [1:0]        wr_port,
  input  logic [7:0]        wr_data,
  output logic              busy,
  output logic              op_pending,
  output logic [WORD_W-1:0] reg_addr,
  output logic [BYTE_W-1:0] op_data,
  output logic              lfo_en,
  output logic [2:0]        lfo_rate,
  output logic [9:0]        tmra_val,
  output logic [7:0]        tmrb_val,
  output logic [1:0]        ch3_mode,
  output logic              csm_on,
  output logic              tmra_load,
  output logic              tmra_en,
  output logic              tmra_clr,
  output logic              tmrb_load,
  output logic              tmrb_en,
  output logic              tmrb_clr,
  output logic [3:0]        key_ops,
  output logic [2:0]        key_chan,
  output logic              key_chan_bad,
  output logic [8:0]        dac_word,
  output logic              dac_on
);
  logic [WORD_W-1:0] word_q, word_n;
  logic              a_en, d_en;
  logic [2:0]        actl, bctl;

  always_comb begin
    word_n = wr_req ? {wr_port[1], wr_data} : word_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_q <= '0;
    else        word_q <= word_n;
  end

  fm_req_strobe u_astb (.clk(clk), .rst_n(rst_n), .set(wr_req & ~wr_port[0]), .fire(a_en));
  fm_req_strobe u_dstb (.clk(clk), .rst_n(rst_n), .set(wr_req &  wr_port[0]), .fire(d_en));

  fm_busy_timer #(.CNT_W(BUSY_CNT_W)) u_busy (
    .clk(clk), .rst_n(rst_n), .kick(d_en), .busy_o(busy)
  );

  fm_addr_track #(.WORD_W(WORD_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .a_en(a_en), .d_en(d_en), .word(word_q),
    .addr_o(reg_addr), .pend_o(op_pending), .data_o(op_data)
  );

  fm_global_dec u_dec (
    .clk(clk), .rst_n(rst_n), .d_en(d_en), .word(word_q), .addr(reg_addr),
    .lfo_en(lfo_en), .lfo_rate(lfo_rate), .tmra_val(tmra_val), .tmrb_val(tmrb_val),
    .ch3_mode(ch3_mode), .csm_on(csm_on), .tmra_ctl(actl), .tmrb_ctl(bctl),
    .key_ops(key_ops), .key_chan(key_chan), .key_chan_bad(key_chan_bad),
    .dac_word(dac_word), .dac_on(dac_on)
  );

  assign {tmra_clr, tmra_en, tmra_load} = actl;
  assign {tmrb_clr, tmrb_en, tmrb_load} = bctl;
endmodule

// File: rtl/fm_host_regs_chk.sv
module fm_host_regs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       a_en,
  input logic       d_en,
  input logic [8:0] word,
  input logic       busy,
  input logic       op_pending,
  input logic [2:0] key_chan,
  input logic       key_chan_bad,
  input logic [7:0] tmrb_val,
  input logic [8:0] dac_word,
  input logic       dac_on
);
  // R2: an enable never lasts two cycles
  p_strobe_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    a_en |=> !a_en);
  // R2: data enable also single
  p_dstrobe_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    d_en |=> !d_en);
  // R3: busy seen two edges after a data enable
  p_busy_after_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
    d_en |-> ##2 busy);
  // R4: address write clears pending
  p_addr_clears_pend_r4: assert property (@(posedge clk) disable iff (!rst_n)
    a_en |=> !op_pending);
  // R5: pending only rises after a data enable
  p_pend_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(op_pending) |-> $past(d_en));
  // R6: high-bank data leaves global fields alone
  p_high_bank_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (d_en && word[8]) |=> ($stable(tmrb_val) && $stable(dac_word) && $stable(dac_on)));
  // R10: invalid channel reports index zero
  p_bad_chan_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    key_chan_bad |-> (key_chan == 3'd0));
endmodule

bind fm_host_regs fm_host_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .a_en(a_en), .d_en(d_en), .word(word_q),
  .busy(busy), .op_pending(op_pending), .key_chan(key_chan),
  .key_chan_bad(key_chan_bad), .tmrb_val(tmrb_val), .dac_word(dac_word),
  .dac_on(dac_on)
);

// File: tb/test_fm_host_regs.sv
`timescale 1ns/1ps
module test_fm_host_regs;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_req = 1'b0;
  logic [1:0] wr_port = '0;
  logic [7:0] wr_data = '0;
  logic busy, op_pending, lfo_en, csm_on, tmra_load, tmra_en, tmra_clr;
  logic tmrb_load, tmrb_en, tmrb_clr, key_chan_bad, dac_on;
  logic [8:0] reg_addr, dac_word;
  logic [7:0] op_data, tmrb_val;
  logic [2:0] lfo_rate, key_chan;
  logic [9:0] tmra_val;
  logic [1:0] ch3_mode;
  logic [3:0] key_ops;

  always #2 clk = ~clk;

  fm_host_regs i_fm_host_regs (
    .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_port(wr_port), .wr_data(wr_data),
    .busy(busy), .op_pending(op_pending), .reg_addr(reg_addr), .op_data(op_data),
    .lfo_en(lfo_en), .lfo_rate(lfo_rate), .tmra_val(tmra_val), .tmrb_val(tmrb_val),
    .ch3_mode(ch3_mode), .csm_on(csm_on), .tmra_load(tmra_load), .tmra_en(tmra_en),
    .tmra_clr(tmra_clr), .tmrb_load(tmrb_load), .tmrb_en(tmrb_en), .tmrb_clr(tmrb_clr),
    .key_ops(key_ops), .key_chan(key_chan), .key_chan_bad(key_chan_bad),
    .dac_word(dac_word), .dac_on(dac_on)
  );

  typedef enum int { F_BUSY, F_PEND, F_ADDR, F_OPD, F_LFO, F_TMRA, F_TMRB, F_MODE,
                     F_KEY, F_DAC, F_DACEN } fld_t;
  typedef struct { fld_t f; int v; string tag; } item_t;
  item_t q[$];
  int checks = 0, fails = 0;
  bit done = 0;

  function automatic int peek(fld_t f);
    case (f)
      F_BUSY: return int'(busy);
      F_PEND: return int'(op_pending);
      F_ADDR: return int'(reg_addr);
      F_OPD:  return int'(op_data);
      F_LFO:  return int'({lfo_en, lfo_rate});
      F_TMRA: return int'(tmra_val);
      F_TMRB: return int'(tmrb_val);
      F_MODE: return int'({ch3_mode, csm_on, tmrb_clr, tmrb_en, tmrb_load,
                           tmra_clr, tmra_en, tmra_load});
      F_KEY:  return int'({key_ops, key_chan_bad, key_chan});
      F_DAC:  return int'(dac_word);
      default: return int'(dac_on);
    endcase
  endfunction

  // monitor: pops expected items and compares against the outputs
  initial begin
    forever begin
      item_t it;
      wait (q.size() != 0);
      it = q.pop_front();
      checks++;
      if (peek(it.f) != it.v) begin
        fails++;
        $display("FAIL %s field=%s actual=0x%0h expected=0x%0h", it.tag, it.f.name(),
                 peek(it.f), it.v);
      end
    end
  end

  task automatic expect_v(fld_t f, int v, string tag);
    item_t it;
    it.f = f; it.v = v; it.tag = tag;
    q.push_back(it);
    wait (q.size() == 0);
    #0;
  endtask

  task automatic wr(logic [1:0] p, logic [7:0] d);
    @(negedge clk); wr_req = 1'b1; wr_port = p; wr_data = d;
    @(negedge clk); wr_req = 1'b0;
    @(negedge clk);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12: reset state
    expect_v(F_BUSY, 0, "R12 busy");
    expect_v(F_ADDR, 0, "R12 addr");
    expect_v(F_MODE, 0, "R12 mode");
    expect_v(F_DAC, 0, "R12 dac");
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);

    // R7 LFO
    wr(2'd0, 8'h22);
    expect_v(F_ADDR, 'h022, "R1 R4 address latched");
    wr(2'd1, 8'h0D);
    expect_v(F_LFO, 'hD, "R7 lfo on rate 5");
    // R3 busy after data write
    @(negedge clk);
    expect_v(F_BUSY, 1, "R3 busy raised");
    repeat (40) @(negedge clk);
    expect_v(F_BUSY, 0, "R3 busy cleared");
    wr(2'd0, 8'h24);
    @(negedge clk);
    expect_v(F_BUSY, 0, "R3 address write no busy");

    // R8 timer A split, timer B
    wr(2'd1, 8'hAB);
    wr(2'd0, 8'h25); wr(2'd1, 8'h03);
    expect_v(F_TMRA, 'h2AF, "R8 timer A full");
    wr(2'd0, 8'h24); wr(2'd1, 8'h12);
    expect_v(F_TMRA, 'h04B, "R8 timer A low kept");
    wr(2'd0, 8'h26); wr(2'd1, 8'h5E);
    expect_v(F_TMRB, 'h5E, "R8 timer B");

    // R2 back-to-back data requests: only the first acts
    @(negedge clk); wr_req = 1'b1; wr_port = 2'd1; wr_data = 8'h3C;
    @(negedge clk); wr_data = 8'hC3;
    @(negedge clk); wr_req = 1'b0;
    @(negedge clk);
    expect_v(F_TMRB, 'h3C, "R2 back-to-back first only");
    wr(2'd1, 8'h55);
    expect_v(F_TMRB, 'h55, "R2 isolated request acts");

    // R9 mode register: {ch3, csm, bclr, ben, bload, aclr, aen, aload}
    wr(2'd0, 8'h27); wr(2'd1, 8'h95);
    expect_v(F_MODE, 'b10_1_000_111, "R9 csm and timer A bits");
    wr(2'd1, 8'h6A);
    expect_v(F_MODE, 'b01_0_111_000, "R9 timer B bits");

    // R10 key-on: {ops, bad, chan}
    wr(2'd0, 8'h28); wr(2'd1, 8'hF6);
    expect_v(F_KEY, 'b1111_0_101, "R10 upper bank channel");
    wr(2'd1, 8'h53);
    expect_v(F_KEY, 'b0101_1_000, "R10 invalid channel");
    wr(2'd1, 8'h01);
    expect_v(F_KEY, 'b0000_0_001, "R10 lower bank channel");

    // R11 DAC
    wr(2'd0, 8'h2A); wr(2'd1, 8'h00);
    expect_v(F_DAC, 'h100, "R11 dac sign flip zero");
    wr(2'd1, 8'hFF);
    expect_v(F_DAC, 'h0FE, "R11 dac sign flip ff");
    wr(2'd0, 8'h2B); wr(2'd1, 8'h80);
    expect_v(F_DACEN, 1, "R11 dac enable on");
    wr(2'd1, 8'h7F);
    expect_v(F_DACEN, 0, "R11 dac enable off");

    // R6 high bank: address 0x126 and data word bit 8
    wr(2'd2, 8'h26);
    expect_v(F_ADDR, 'h126, "R1 high bank address");
    wr(2'd1, 8'h77);
    expect_v(F_TMRB, 'h55, "R6 high address no decode");
    wr(2'd0, 8'h26); wr(2'd3, 8'h99);
    expect_v(F_TMRB, 'h55, "R6 high data word no decode");

    // R4 R5 operator path
    wr(2'd0, 8'h30);
    expect_v(F_PEND, 0, "R4 address clears pending");
    wr(2'd1, 8'h5A);
    expect_v(F_PEND, 1, "R5 pending set");
    expect_v(F_OPD, 'h5A, "R5 data captured");
    wr(2'd0, 8'h0F);
    expect_v(F_ADDR, 'h030, "R4 low address ignored");
    expect_v(F_PEND, 0, "R4 pending cleared");
    wr(2'd1, 8'h11);
    expect_v(F_PEND, 0, "R5 no valid address");
    expect_v(F_OPD, 'h5A, "R5 data held");

    done = 1;
    summary();
  end
endmodule